// File: doc/BRIEF.md
# Configurable Digital Downconverter Chain

The block turns a stream of real signed samples into complex baseband samples at a reduced rate. Each accepted sample is multiplied by a numerically controlled oscillator, so that the chosen carrier frequency moves down to zero. The result then passes through one or two cascaded half-band decimators, an optional fixed gain of two, and an optional stage that turns the complex stream back into a real one. The stages always run in that order. A constant offset present at the input is treated like any other tone and is shifted, not removed.

The configuration inputs are static. They are a phase increment, two half-band enables, a gain enable and an output-mode select. The block captures them while reset is asserted and until the first sample is accepted, and holds them after that. The input is qualified by a valid bit that may have gaps. The output carries its own one-cycle valid strobe, which fires once per decimated sample.

Top module: `ddc_chain`

## Requirements
- R1: While reset is asserted, and after it until a decimated result exists, out_valid is 0 and out_i and out_q are 0. Reset clears the phase accumulator, both filter delay lines and both decimation phase bits.
- R2: The 32-bit phase starts at 0 and advances by tune_word once per accepted sample. Sample k therefore uses phase k*tune_word. Bits 31:30 select the quadrant and bits 29:22 index a 256-entry quarter-wave table. A phase of 0 gives cos 32767 and sin 0; a phase of 2^30 gives cos 0 and sin 32767; a phase of 2^31 gives cos -32767 and sin 0. The mixer produces I = (x*cos)>>>15 and Q = (x*(-sin))>>>15.
- R3: Each half-band stage is an 11-tap filter with coefficients h0..h10 = 192, 0, -1600, 0, 9600, 16384, 9600, 0, -1600, 0, 192. A stage's delay line starts at zero. The stage produces y = sum(h_j*x[k-j])>>>15, saturated to 16 bits, only for the 2nd, 4th, 6th... accepted input k.
- R4: The decimation is 4 only when hb1_en and hb2_en are both 1, and the second stage then filters the first stage's outputs. Every other combination, hb2_en alone included, gives a decimation of 2.
- R5: With gain_en = 1 each lane is doubled and saturated to the range -32768..32767. With gain_en = 0 it passes through unchanged.
- R6: With real_out = 0, out_i and out_q carry the I and Q lanes after the gain stage.
- R7: With real_out = 1, output number n (counted from 0 since reset) carries I, -Q, -I, Q on out_i for n mod 4 = 0, 1, 2, 3. The negation saturates, so -32768 becomes 32767. out_q is 0 in this mode.
- R8: Configuration inputs are captured while reset is asserted or before the first accepted sample. Changes made after that do not affect the output.
- R9: No offset is removed. A constant input x with tune_word 0 settles to (x*32767)>>>15 on out_i.
- R10: out_valid is high for single cycles and never on two consecutive cycles. Gaps in in_valid do not change the output values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | 16 | Signed real input sample |
| tune_word | input | 32 | Oscillator phase increment per sample |
| hb1_en | input | 1 | First half-band enable |
| hb2_en | input | 1 | Second half-band enable (effective only with hb1_en) |
| gain_en | input | 1 | Enables the saturating gain of two |
| real_out | input | 1 | 1 selects real output, 0 selects complex |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | In-phase lane, or the real result |
| out_q | output | 16 | Quadrature lane, 0 in real mode |

## Verification
The gain stage's saturation and the complex-to-real stage's negation can act on the same output sample. A full-scale negative constant with gain and real mode on first clamps to -32768 and then must be negated to +32767. The sweep produces this case, and the expected value comes from the bench's own step-by-step arithmetic. A second pairing is a configuration change in the middle of the stream, which arrives while samples are being mixed. The frozen capture is judged by comparing the whole output sequence with one computed from the original settings.

// File: rtl/ddc_chain.sv
module ddc_chain #(
  parameter int DW   = 16,
  parameter int PW   = 32,
  parameter int LAW  = 8,
  parameter int CW   = 16,
  parameter int H0   = 192,
  parameter int H2   = -1600,
  parameter int H4   = 9600,
  parameter int HC   = 16384
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic [PW-1:0]        tune_word,
  input  logic                 hb1_en,
  input  logic                 hb2_en,
  input  logic                 gain_en,
  input  logic                 real_out,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);

  localparam int LN  = 1 << LAW;
  localparam int FS  = (1 << (DW - 1)) - 1;
  localparam int NT  = 11;
  localparam int CSH = CW - 1;
  localparam int ACW = DW + CW + 4;
  localparam logic signed [DW-1:0]  MAXV = DW'(FS);
  localparam logic signed [DW-1:0]  MINV = -MAXV - 1;
  localparam logic signed [ACW-1:0] HI   = ACW'(FS);
  localparam logic signed [ACW-1:0] LO   = -HI - 1;

  function automatic int qval(int k);
    return $rtoi($sin(3.141592653589793 * k / (2.0 * LN)) * FS + 0.5);
  endfunction

  function automatic logic signed [DW-1:0] sat(input logic signed [ACW-1:0] v);
    return (v > HI) ? MAXV : ((v < LO) ? MINV : v[DW-1:0]);
  endfunction

  function automatic logic signed [DW-1:0] nsat(input logic signed [DW-1:0] v);
    return (v == MINV) ? MAXV : -v;
  endfunction

  // configuration capture
  logic [PW-1:0] c_tw;
  logic          c_hb1, c_hb2, c_gain, c_real, started;

  always_ff @(posedge clk) begin
    if (rst) started <= 1'b0;
    else if (in_valid) started <= 1'b1;
    if (rst || !started) begin
      c_tw   <= tune_word;
      c_hb1  <= hb1_en;
      c_hb2  <= hb2_en;
      c_gain <= gain_en;
      c_real <= real_out;
    end
  end

  // R8
  // cfg_frozen_chk
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    started |=> $stable(c_tw) && $stable({c_hb1, c_hb2, c_gain, c_real}));

  // oscillator
  logic [PW-1:0]         phase;
  logic signed [DW-1:0]  qlut [LN];
  logic [1:0]            quad;
  logic [LAW-1:0]        idx, nidx;
  logic signed [DW-1:0]  qa, qb, cosv, sinv;
  logic signed [2*DW-1:0] p_i, p_q;

  for (genvar k = 0; k < LN; k++) begin : g_lut
    assign qlut[k] = DW'(qval(k));
  end

  assign quad = phase[PW-1 -: 2];
  assign idx  = phase[PW-3 -: LAW];
  assign nidx = LAW'(0) - idx;
  assign qa   = qlut[idx];
  assign qb   = (idx == '0) ? MAXV : qlut[nidx];

  always_comb begin
    unique case (quad)
      2'd0:    begin sinv = qa;  cosv = qb;  end
      2'd1:    begin sinv = qb;  cosv = -qa; end
      2'd2:    begin sinv = -qa; cosv = -qb; end
      default: begin sinv = -qb; cosv = qa;  end
    endcase
    p_i = in_data * cosv;
    p_q = in_data * (-sinv);
  end

  logic signed [DW-1:0] mix_i, mix_q;
  logic                 mix_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      mix_v <= 1'b0;
      mix_i <= '0;
      mix_q <= '0;
    end else begin
      mix_v <= in_valid;
      if (in_valid) begin
        phase <= phase + c_tw;
        mix_i <= DW'(p_i >>> CSH);
        mix_q <= DW'(p_q >>> CSH);
      end
    end
  end

  // R2
  // phase_hold_chk
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && !$past(in_valid) |-> $stable(phase));

  // half-band stages
  logic [1:0]           sv_in, sv_out, ph;
  logic signed [DW-1:0] st_in  [2][2];
  logic signed [DW-1:0] st_out [2][2];

  assign sv_in[0]    = mix_v;
  assign sv_in[1]    = sv_out[0];
  assign st_in[0][0] = mix_i;
  assign st_in[0][1] = mix_q;
  assign st_in[1][0] = st_out[0][0];
  assign st_in[1][1] = st_out[0][1];

  for (genvar s = 0; s < 2; s++) begin : g_hb
    logic ph_r, vo_r;
    assign ph[s]     = ph_r;
    assign sv_out[s] = vo_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        ph_r <= 1'b0;
        vo_r <= 1'b0;
      end else begin
        if (sv_in[s]) ph_r <= ~ph_r;
        vo_r <= sv_in[s] & ph_r;
      end
    end

    for (genvar l = 0; l < 2; l++) begin : g_lane
      logic signed [DW-1:0]  tap [NT-1];
      logic signed [DW-1:0]  x, y_r;
      logic signed [ACW-1:0] acc;

      assign x = st_in[s][l];
      assign st_out[s][l] = y_r;

      always_comb
        acc = ACW'(H0) * (ACW'(x) + ACW'(tap[9]))
            + ACW'(H2) * (ACW'(tap[1]) + ACW'(tap[7]))
            + ACW'(H4) * (ACW'(tap[3]) + ACW'(tap[5]))
            + ACW'(HC) * ACW'(tap[4]);

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int k = 0; k < NT - 1; k++) tap[k] <= '0;
          y_r <= '0;
        end else if (sv_in[s]) begin
          tap[0] <= x;
          for (int k = 1; k < NT - 1; k++) tap[k] <= tap[k-1];
          if (ph_r) y_r <= sat(acc >>> CSH);
        end
      end
    end
  end

  // R3
  // hb_pair_chk
  hb_pair_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && sv_out[0] |-> $past(sv_in[0]) && $past(ph[0]));

  // gain and complex-to-real
  logic                 dec4, dv;
  logic signed [DW-1:0] di, dq, gi, gq, ri;
  logic [1:0]           ocnt;

  assign dec4 = c_hb1 & c_hb2;
  assign dv   = dec4 ? sv_out[1] : sv_out[0];
  assign di   = dec4 ? st_out[1][0] : st_out[0][0];
  assign dq   = dec4 ? st_out[1][1] : st_out[0][1];
  assign gi   = c_gain ? sat(ACW'(di) <<< 1) : di;
  assign gq   = c_gain ? sat(ACW'(dq) <<< 1) : dq;

  always_comb begin
    unique case (ocnt)
      2'd0:    ri = gi;
      2'd1:    ri = nsat(gq);
      2'd2:    ri = nsat(gi);
      default: ri = gq;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ocnt      <= '0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= dv;
      if (dv) begin
        ocnt  <= ocnt + 2'd1;
        out_i <= c_real ? ri : gi;
        out_q <= c_real ? '0 : gq;
      end
    end
  end

  // R10
  // single_strobe_chk
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R7
  // real_q_chk
  real_q_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && c_real |-> out_q == '0);

  // R1
  // reset_quiet_chk
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

endmodule

// File: tb/sim_ddc_chain.sv
module sim_ddc_chain;
  localparam int CLK_NS = 10;
  localparam int N      = 32;
  localparam int A      = 32767;
  localparam int HCO [11] = '{192, 0, -1600, 0, 9600, 16384, 9600, 0, -1600, 0, 192};

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic [31:0] tune = '0;
  logic hb1 = 1'b0, hb2 = 1'b0, gain = 1'b0, realm = 1'b0;
  logic out_valid;
  logic signed [15:0] out_i, out_q;

  int total = 0, fails = 0, ncap = 0, b2b = 0;
  bit prev_v = 1'b0;
  int got_i [64], got_q [64];
  int xs [64], ei [64], eq [64];
  int nexp = 0;

  always #(CLK_NS/2) clk = ~clk;

  ddc_chain u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .tune_word(tune), .hb1_en(hb1), .hb2_en(hb2), .gain_en(gain),
    .real_out(realm), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (ncap < 64) begin
        got_i[ncap] = int'(out_i);
        got_q[ncap] = int'(out_q);
      end
      ncap = ncap + 1;
      if (prev_v) b2b = b2b + 1;
    end
    prev_v = out_valid;
  end

  function automatic int sat16(int v);
    return (v > 32767) ? 32767 : ((v < -32768) ? -32768 : v);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total = total + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model(int tq, int h1, int h2, int gn, int rl);
    int a_i [64], a_q [64], b_i [64], b_q [64];
    int na, nb, c, s, q, ai, aq, gi, gq;
    for (int k = 0; k < N; k++) begin
      q = (k * tq) % 4;
      c = (q == 0) ? A : ((q == 2) ? -A : 0);
      s = (q == 1) ? A : ((q == 3) ? -A : 0);
      a_i[k] = (xs[k] * c) >>> 15;
      a_q[k] = (xs[k] * (-s)) >>> 15;
    end
    na = N;
    for (int p = 0; p < ((h1 != 0 && h2 != 0) ? 2 : 1); p++) begin
      nb = 0;
      for (int k = 1; k < na; k += 2) begin
        ai = 0; aq = 0;
        for (int j = 0; j < 11; j++)
          if (k - j >= 0) begin
            ai += HCO[j] * a_i[k-j];
            aq += HCO[j] * a_q[k-j];
          end
        b_i[nb] = sat16(ai >>> 15);
        b_q[nb] = sat16(aq >>> 15);
        nb++;
      end
      for (int k = 0; k < nb; k++) begin a_i[k] = b_i[k]; a_q[k] = b_q[k]; end
      na = nb;
    end
    for (int k = 0; k < na; k++) begin
      gi = (gn != 0) ? sat16(2 * a_i[k]) : a_i[k];
      gq = (gn != 0) ? sat16(2 * a_q[k]) : a_q[k];
      if (rl != 0) begin
        case (k % 4)
          0: ei[k] = gi;
          1: ei[k] = sat16(-gq);
          2: ei[k] = sat16(-gi);
          default: ei[k] = gq;
        endcase
        eq[k] = 0;
      end else begin
        ei[k] = gi;
        eq[k] = gq;
      end
    end
    nexp = na;
  endtask

  task automatic run(int tq, int h1, int h2, int gn, int rl, int pat, int gap, int swap, string tag);
    for (int k = 0; k < N; k++)
      case (pat)
        0: xs[k] = ((k * 40503 + tq * 977 + h1 * 131 + gn * 17) & 16'hFFFF) - 32768;
        1: xs[k] = 30000;
        2: xs[k] = -32768;
        default: xs[k] = ((k % 4) < 2) ? 32767 : -32767;
      endcase
    model(tq, h1, h2, gn, rl);
    tune = 32'(tq) << 30; hb1 = h1[0]; hb2 = h2[0]; gain = gn[0]; realm = rl[0];
    rst = 1'b1;
    repeat (3) @(negedge clk);
    ncap = 0;
    rst = 1'b0;
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 16'(xs[k]);
      if (swap != 0 && k == 4) begin
        tune = 32'h4000_0000; hb2 = 1'b1; gain = 1'b1; realm = 1'b1;
      end
      if (gap != 0) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (12) @(negedge clk);
    chk(ncap == nexp, (h1 != 0 && h2 != 0) ? "R4" : "R3", "output count", ncap, nexp);
    for (int k = 0; k < nexp && k < ncap; k++) begin
      chk(got_i[k] == ei[k], tag, $sformatf("out_i[%0d]", k), got_i[k], ei[k]);
      chk(got_q[k] == eq[k], tag, $sformatf("out_q[%0d]", k), got_q[k], eq[k]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total = total + 1;
    fails = fails + 1;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int idx;
    string tg;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(out_i == 0, "R1", "out_i in reset", int'(out_i), 0);
    chk(out_q == 0, "R1", "out_q in reset", int'(out_q), 0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    chk(ncap == 0, "R1", "strobes with no input", ncap, 0);

    // R9: constant offset is carried through with tune word 0
    run(0, 1, 0, 0, 0, 1, 0, 0, "R9");
    xs[0] = 1000;
    for (int k = 0; k < N; k++) xs[k] = 1000;
    model(0, 1, 0, 0, 0);
    tune = '0; hb1 = 1'b1; hb2 = 1'b0; gain = 1'b0; realm = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    ncap = 0;
    rst = 1'b0;
    for (int k = 0; k < N; k++) begin
      @(negedge clk); in_valid = 1'b1; in_data = 16'sd1000;
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (12) @(negedge clk);
    chk(ncap == N / 2, "R3", "dc run count", ncap, N / 2);
    chk(got_i[N/2-1] == ((1000 * 32767) >>> 15), "R9", "settled dc out_i", got_i[N/2-1], (1000 * 32767) >>> 15);
    chk(got_q[N/2-1] == 0, "R6", "complex out_q at dc", got_q[N/2-1], 0);

    // R8: configuration changed mid-stream is ignored
    run(0, 1, 0, 0, 0, 0, 0, 1, "R8");

    // sweep over all configurations
    for (int tq = 0; tq < 3; tq++)
      for (int hb = 0; hb < 4; hb++)
        for (int gn = 0; gn < 2; gn++)
          for (int rl = 0; rl < 2; rl++) begin
            idx = ((tq * 4 + hb) * 2 + gn) * 2 + rl;
            if (rl != 0) tg = "R7";
            else if (gn != 0) tg = "R5";
            else if (hb >= 2) tg = "R4";
            else if (tq != 0) tg = "R2";
            else tg = "R6";
            run(tq, hb % 2, hb / 2, gn, rl, (idx + idx / 4) % 4, (idx % 3 == 0) ? 1 : 0, 0, tg);
          end

    chk(b2b == 0, "R10", "back-to-back strobes", b2b, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule